// File: doc/BRIEF.md
# Audio Port Control and Status Register Bank

This block is the software-facing register bank of an audio serial port. It decodes a simple single-cycle register bus and holds a control word and a status word. It also passes a data port through to the serial engine. The control word carries a soft-reset bit, a clock-gate bit, a run bit, an interrupt enable and the frame-format and clock-ratio fields. The engine and the clock dividers sit outside the block and read these fields from `ctrl_o`.

Every register appears at three word addresses inside its 16-byte slot. Offset 0x0 is a plain read/write address. Offset 0x4 is an OR alias and offset 0x8 is an AND-NOT alias. Software can therefore flip single bits in one bus write, with no read-modify-write sequence. The status word collects the engine's FIFO underflow and overflow events as sticky flags. Software acknowledges a flag by writing a 1 to it through the clear alias. An interrupt line reports the enabled flags.

Top module: `aport_csr`

## Requirements
- R1: After `rst_ni` is released, the control word reads 0xC000_0000 (bit 31 soft reset = 1, bit 30 clock gate = 1, all other bits 0). Both status flags read 0, `irq_o` is 0 and `tx_push_o` is 0.
- R2: A write at byte address 0x00 replaces the control word with the write data, ANDed with the writable mask 0xC01F_477F.
- R3: A write at 0x04 sets exactly the control bits that are 1 in the write data. All other control bits are unchanged.
- R4: A write at 0x08 clears exactly the control bits that are 1 in the write data. All other control bits are unchanged.
- R5: `engine_en_o` is 1 only when the run bit (bit 0) is 1, soft reset (bit 31) is 0 and clock gate (bit 30) is 0.
- R6: While `busy_i` is 1, control writes leave the format and clock fields (mask 0x001F_077E) unchanged. The other control bits still follow R2 to R4.
- R7: A pulse on `underflow_i` sets status bit 1 and a pulse on `overflow_i` sets status bit 2, in the cycle after the pulse. A set flag stays set until a write at 0x18 has a 1 in that bit position. If an event and its clear arrive in the same cycle, the event wins. Status bit 0 reads `busy_i`.
- R8: Writes at the status plain address 0x10 and its set alias 0x14 do not change the status flags.
- R9: `irq_o` equals control bit 14 ANDed with the OR of the two status flags. It is high from the cycle after a flag is set until every enabled flag is cleared.
- R10: While soft reset is 1, both status flags are held at 0, reads of the data port return 0, and data-port writes do not pulse `tx_push_o`.
- R11: A read at 0x20 returns `rx_data_i`. A write at 0x20 pulses `tx_push_o` for one cycle, in the cycle after the write, with `tx_data_o` equal to the write data.
- R12: Reads at the reserved alias (slot offset 0xC), at unmapped slots or at addresses not aligned to a word return 0. Writes to these addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, same cycle as the request |
| busy_i | input | 1 | Serial engine busy |
| underflow_i | input | 1 | FIFO underflow event pulse |
| overflow_i | input | 1 | FIFO overflow event pulse |
| rx_data_i | input | 32 | Received sample word from the engine |
| tx_data_o | output | 32 | Sample word for the engine |
| tx_push_o | output | 1 | One-cycle strobe for tx_data_o |
| ctrl_o | output | 32 | Current control word |
| engine_en_o | output | 1 | Engine run enable |
| irq_o | output | 1 | FIFO error interrupt |

## Verification
A wrong alias merge or a bad protect mask shows on `ctrl_o` in the cycle right after the write, so the bench compares `ctrl_o` after every access. A sticky flag that is lost or set by mistake shows on `irq_o` one cycle after the event or the clear, whenever the enable bit is set. It also shows on the next status read. A soft reset that does not reach the status or data path shows as nonzero flags, nonzero data reads or a stray `tx_push_o` in the first cycle after it takes effect.

// File: rtl/aport_csr_pkg.sv
package aport_csr_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [1:0] {
    AL_PLAIN = 2'd0,
    AL_SET   = 2'd1,
    AL_CLR   = 2'd2,
    AL_NONE  = 2'd3
  } alias_e;

  localparam logic [DW-1:0] CTRL_RST   = 32'hC000_0000;
  localparam logic [DW-1:0] CTRL_WMASK = 32'hC01F_477F;
  localparam logic [DW-1:0] CTRL_PROT  = 32'h001F_077E;

  localparam int unsigned CB_RUN  = 0;
  localparam int unsigned CB_IE   = 14;
  localparam int unsigned CB_GATE = 30;
  localparam int unsigned CB_SRST = 31;

  localparam int unsigned RI_CTRL = 0;
  localparam int unsigned RI_STAT = 1;
  localparam int unsigned RI_DATA = 2;
  localparam int unsigned NREG    = 3;

  function automatic logic [DW-1:0] alias_merge(input logic [DW-1:0] q,
                                                input logic [DW-1:0] d,
                                                input alias_e        al);
    unique case (al)
      AL_PLAIN: alias_merge = d;
      AL_SET:   alias_merge = q | d;
      AL_CLR:   alias_merge = q & ~d;
      default:  alias_merge = q;
    endcase
  endfunction
endpackage

// File: rtl/aport_csr_decode.sv
module aport_csr_decode
  import aport_csr_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned NR = NREG
) (
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output logic [NR-1:0] wr_sel_o,
  output logic [NR-1:0] rd_sel_o,
  output alias_e        alias_o
);
  localparam int unsigned IW = AW - 4;

  logic [IW-1:0] idx;
  logic          ok;

  assign idx     = addr_i[AW-1:4];
  assign alias_o = alias_e'(addr_i[3:2]);
  // reserved alias and byte-misaligned accesses hit nothing
  assign ok      = req_i && (addr_i[1:0] == 2'b00) && (alias_o != AL_NONE);

  for (genvar r = 0; r < NR; r++) begin : g_sel
    logic hit;
    assign hit         = ok && (idx == IW'(r));
    assign wr_sel_o[r] = hit && we_i;
    assign rd_sel_o[r] = hit && !we_i;
  end
endmodule

// File: rtl/aport_csr_ctrl.sv
module aport_csr_ctrl
  import aport_csr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  alias_e        alias_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          busy_i,
  output logic [DW-1:0] ctrl_o
);
  logic [DW-1:0] ctrl_q, merged, ctrl_d;

  always_comb begin
    merged = alias_merge(ctrl_q, wdata_i, alias_i);
    if (busy_i) merged = (ctrl_q & CTRL_PROT) | (merged & ~CTRL_PROT);
    ctrl_d = wr_i ? (merged & CTRL_WMASK) : ctrl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CTRL_RST;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  // R6
  prot_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ((ctrl_q & CTRL_PROT) == ($past(ctrl_q) & CTRL_PROT)));

  // R3
  set_keeps_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && alias_i == AL_SET) |=> ((ctrl_q & $past(ctrl_q)) == $past(ctrl_q)));

  // R4
  clr_keeps_zeros_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && alias_i == AL_CLR) |=> ((ctrl_q & ~$past(ctrl_q)) == '0));
endmodule

// File: rtl/aport_csr_stat.sv
module aport_csr_stat
  import aport_csr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       srst_i,
  input  logic       wr_i,
  input  alias_e     alias_i,
  input  logic [1:0] wbits_i,
  input  logic       uf_i,
  input  logic       ov_i,
  output logic [1:0] flags_o
);
  logic [1:0] flags_q, flags_d, clr;

  // only the clear alias may acknowledge flags
  assign clr = (wr_i && alias_i == AL_CLR) ? wbits_i : 2'b00;

  always_comb begin
    flags_d = (flags_q & ~clr) | {ov_i, uf_i};
    if (srst_i) flags_d = 2'b00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= 2'b00;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R7
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q[0] && !clr[0] && !srst_i) |=> flags_q[0]);

  // R8
  plain_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && alias_i != AL_CLR && !uf_i && !ov_i && !srst_i) |=> $stable(flags_q));

  // R10
  srst_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (flags_q == 2'b00));
endmodule

// File: rtl/aport_csr.sv
module aport_csr
  import aport_csr_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          busy_i,
  input  logic          underflow_i,
  input  logic          overflow_i,
  input  logic [31:0]   rx_data_i,
  output logic [31:0]   tx_data_o,
  output logic          tx_push_o,
  output logic [31:0]   ctrl_o,
  output logic          engine_en_o,
  output logic          irq_o
);
  logic [NREG-1:0] wr_sel, rd_sel;
  alias_e          alias_w;
  logic [DW-1:0]   ctrl;
  logic [1:0]      flags;
  logic            srst;
  logic            push_q;
  logic [DW-1:0]   txd_q;

  aport_csr_decode #(.AW(AW), .NR(NREG)) u_dec (
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wr_sel_o (wr_sel),
    .rd_sel_o (rd_sel),
    .alias_o  (alias_w)
  );

  aport_csr_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_sel[RI_CTRL]),
    .alias_i (alias_w),
    .wdata_i (wdata_i),
    .busy_i  (busy_i),
    .ctrl_o  (ctrl)
  );

  assign srst = ctrl[CB_SRST];

  aport_csr_stat u_stat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_i  (srst),
    .wr_i    (wr_sel[RI_STAT]),
    .alias_i (alias_w),
    .wbits_i (wdata_i[2:1]),
    .uf_i    (underflow_i),
    .ov_i    (overflow_i),
    .flags_o (flags)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_sel[RI_CTRL]) rdata_o = ctrl;
    if (rd_sel[RI_STAT]) rdata_o = {29'd0, flags, busy_i};
    if (rd_sel[RI_DATA]) rdata_o = srst ? '0 : rx_data_i;
  end

  // data port accepts only its plain address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_q <= 1'b0;
      txd_q  <= '0;
    end else begin
      push_q <= wr_sel[RI_DATA] && alias_w == AL_PLAIN && !srst;
      if (wr_sel[RI_DATA] && alias_w == AL_PLAIN && !srst) txd_q <= wdata_i;
    end
  end

  assign tx_push_o   = push_q;
  assign tx_data_o   = txd_q;
  assign ctrl_o      = ctrl;
  assign engine_en_o = ctrl[CB_RUN] && !ctrl[CB_SRST] && !ctrl[CB_GATE];
  assign irq_o       = ctrl[CB_IE] && (|flags);

  // R5
  en_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    engine_en_o |-> (ctrl_o[CB_RUN] && !ctrl_o[CB_SRST]));

  // R9
  irq_needs_ie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctrl_o[CB_IE]);

  // R11
  push_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |-> $past(req_i && we_i));

  // R10
  push_no_srst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |-> !$past(ctrl_o[CB_SRST]));
endmodule

// File: tb/aport_csr_bench.sv
module aport_csr_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        busy_i = 1'b0, underflow_i = 1'b0, overflow_i = 1'b0;
  logic [31:0] rx_data_i = '0, tx_data_o, ctrl_o;
  logic        tx_push_o, engine_en_o, irq_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_ctrl;
  logic [1:0]  m_flags;

  localparam logic [31:0] WMASK = 32'hC01F_477F;
  localparam logic [31:0] PROT  = 32'h001F_077E;

  always #5 clk_i = ~clk_i;

  aport_csr u_aport_csr (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] a, input logic b, input logic [31:0] rx);
    logic [1:0] al = a[3:2];
    if (al == 2'd3 || a[1:0] != 2'd0) return 32'h0;
    case (a[7:4])
      4'd0: return m_ctrl;
      4'd1: return {29'd0, m_flags, b};
      4'd2: return m_ctrl[31] ? 32'h0 : rx;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] ctrl_nxt(input logic we, input logic [7:0] a,
                                           input logic [31:0] d, input logic b);
    logic [31:0] m;
    if (!(we && a[7:4] == 4'd0 && a[1:0] == 2'd0 && a[3:2] != 2'd3)) return m_ctrl;
    case (a[3:2])
      2'd0: m = d;
      2'd1: m = m_ctrl | d;
      default: m = m_ctrl & ~d;
    endcase
    if (b) m = (m_ctrl & PROT) | (m & ~PROT);
    return m & WMASK;
  endfunction

  function automatic logic [1:0] flags_nxt(input logic we, input logic [7:0] a,
                                           input logic [31:0] d, input logic u, input logic o);
    logic [1:0] f = m_flags;
    if (m_ctrl[31]) return 2'b00;
    if (we && a == 8'h18) f = f & ~d[2:1];
    return f | {o, u};
  endfunction

  task automatic op(input logic we, input logic [7:0] a, input logic [31:0] d,
                    input logic b, input logic u, input logic o, input logic [31:0] rx,
                    input string tag);
    logic [31:0] nc;
    logic [1:0]  nf;
    logic        npush;
    req_i = 1'b1; we_i = we; addr_i = a; wdata_i = d;
    busy_i = b; underflow_i = u; overflow_i = o; rx_data_i = rx;
    #1;
    if (!we) chk(rdata_o, exp_rd(a, b, rx), tag);
    nc    = ctrl_nxt(we, a, d, b);
    nf    = flags_nxt(we, a, d, u, o);
    npush = we && a == 8'h20 && !m_ctrl[31];
    @(posedge clk_i); #1;
    m_ctrl = nc; m_flags = nf;
    req_i = 1'b0; we_i = 1'b0; underflow_i = 1'b0; overflow_i = 1'b0;
    chk(ctrl_o, m_ctrl, {tag, " ctrl"});
    chk({31'd0, irq_o}, {31'd0, m_ctrl[14] & (|m_flags)}, "R9 irq");
    chk({31'd0, engine_en_o}, {31'd0, m_ctrl[0] & ~m_ctrl[31] & ~m_ctrl[30]}, "R5 en");
    chk({31'd0, tx_push_o}, {31'd0, npush}, "R11 push");
    if (npush) chk(tx_data_o, d, "R11 txdata");
    @(negedge clk_i);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] addrs [9];
    addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h20, 8'h31};
    void'($urandom(32'h5EED_0042));
    m_ctrl = 32'hC000_0000; m_flags = 2'b00;
    #23 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(ctrl_o, 32'hC000_0000, "R1 ctrl");
    chk({30'd0, irq_o, tx_push_o}, 32'h0, "R1 irq/push");
    op(1'b0, 8'h10, 0, 0, 0, 0, 0, "R1 status");
    // R10 soft reset active: events dropped, data reads zero, no push
    op(1'b0, 8'h00, 0, 0, 1, 1, 0, "R10 evt");
    op(1'b0, 8'h10, 0, 0, 0, 0, 0, "R10 flags");
    op(1'b0, 8'h20, 0, 0, 0, 0, 32'hDEAD_BEEF, "R10 rd");
    op(1'b1, 8'h20, 32'h1234, 0, 0, 0, 0, "R10 wr");
    // R4 clear soft reset and gate via clear alias
    op(1'b1, 8'h08, 32'hC000_0000, 0, 0, 0, 0, "R4 clr");
    // R3 set run and irq enable
    op(1'b1, 8'h04, 32'h0000_4001, 0, 0, 0, 0, "R3 set");
    // R2 plain write with masked bits
    op(1'b1, 8'h00, 32'hFFFF_FFFF, 0, 0, 0, 0, "R2 plain");
    op(1'b1, 8'h00, 32'h0000_4001, 0, 0, 0, 0, "R2 plain");
    // R6 protected fields frozen while busy
    op(1'b1, 8'h04, 32'h001F_077E, 1, 0, 0, 0, "R6 busy");
    op(1'b1, 8'h04, 32'h001F_077E, 0, 0, 0, 0, "R6 idle");
    op(1'b1, 8'h00, 32'h0000_4000, 1, 0, 0, 0, "R6 busy plain");
    // R7 sticky flags
    op(1'b0, 8'h40, 0, 0, 1, 0, 0, "R12 unmapped/R7 uf");
    op(1'b0, 8'h10, 0, 0, 0, 0, 0, "R7 uf read");
    // R8 plain and set alias ignored
    op(1'b1, 8'h10, 32'h0, 0, 0, 0, 0, "R8 plain");
    op(1'b1, 8'h14, 32'h6, 0, 0, 0, 0, "R8 set");
    op(1'b0, 8'h10, 0, 1, 0, 0, 0, "R8 read");
    // R7 clear with simultaneous event: event wins
    op(1'b1, 8'h18, 32'h2, 0, 1, 1, 0, "R7 race");
    op(1'b1, 8'h18, 32'h6, 0, 0, 0, 0, "R7 clr");
    op(1'b0, 8'h10, 0, 0, 0, 0, 0, "R7 cleared");
    // R11 data port
    op(1'b0, 8'h20, 0, 0, 0, 0, 32'hA5A5_0001, "R11 rd");
    op(1'b1, 8'h20, 32'h0BAD_F00D, 0, 0, 0, 0, "R11 wr");
    // R12 reserved alias and misaligned
    op(1'b1, 8'h0C, 32'hFFFF_FFFF, 0, 0, 0, 0, "R12 wr rsv");
    op(1'b0, 8'h0C, 0, 0, 0, 0, 0, "R12 rd rsv");
    op(1'b1, 8'h02, 32'hFFFF_FFFF, 0, 0, 0, 0, "R12 misaligned");
    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      logic [31:0] d = $urandom;
      logic [7:0]  a = addrs[$urandom % 9];
      if ($urandom % 4 != 0) d[31] = 1'b0;
      op(($urandom % 2) == 0, a, d, ($urandom % 3) == 0, ($urandom % 5) == 0,
         ($urandom % 6) == 0, $urandom, "R2/R3/R4/R6/R7/R8 rand");
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule